// File: doc/BRIEF.md
# Paged RAM Bank Mapper

This block lets a CPU with a 16-bit address space reach a 512 KB RAM. The CPU space is split into four 16 KB windows, and each window is backed by one of 32 RAM blocks of 16 KB. The two top CPU address bits pick the window. The window's bank register supplies a 5-bit block number. That number is joined with the low 14 CPU address bits to form the 19-bit physical RAM address.

The bank registers are loaded by CPU I/O writes. The mapper shares its port space with the video register port. It claims a write only when I/O address bit 15 is low and data bits 7 and 6 are both high; all other writes belong to the neighbour. A mode input selects how a claimed write is used. In extended mode the write loads the block number of one window, chosen by I/O address bits 9:8. In compatibility mode the write carries an expansion-style configuration code, and the mapper expands that code into all four window registers at once. The mode input takes effect only at the moment of a write. The current map stays in place when the mode changes.

Top module: `paged_ram_mapper`

## Requirements
- R1: An I/O write (`io_wr` high at a rising clock edge) is claimed only when `io_addr[15]` is 0 and `io_data[7:6]` is 2'b11. Any other write leaves all four window registers unchanged.
- R2: While reset (`rst_n` low) is asserted, windows 0..3 map to blocks 0, 1, 2 and 3.
- R3: `ram_addr[13:0]` always equals `cpu_addr[13:0]`. `ram_addr[18:14]` is the block of window `cpu_addr[15:14]`: window 0 covers 0000-3FFF, 1 covers 4000-7FFF, 2 covers 8000-BFFF and 3 covers C000-FFFF. The output is combinational from the registers.
- R4: In extended mode (`ext_mode`=1), a claimed write sets the window selected by `io_addr[9:8]` to block `io_data[4:0]` from the next cycle on. The other three windows are unchanged.
- R5: In extended mode, `io_data[5]` has no effect on the block loaded.
- R6: In compatibility mode (`ext_mode`=0), a claimed write loads all four windows from the code in `io_data[5:0]`, whatever the value of `io_addr[9:8]`. Group G = `io_data[5:3]` names the group blocks {G,0}..{G,3}. The layout L = `io_data[2:0]` gives windows 0..3 as follows:
  - L=0: 0,1,2,3
  - L=1: 0,1,2,{G,3}
  - L=2: {G,0},{G,1},{G,2},{G,3}
  - L=3: 0,3,2,{G,3}
  - L=4..7: 0,{G,L-4},2,3
- R7: Changing `ext_mode` without a claimed write does not alter the map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | I/O write strobe, one sample per clock |
| io_addr | input | 16 | I/O port address of the write |
| io_data | input | 8 | I/O write data |
| ext_mode | input | 1 | 1 = per-window mode, 0 = compatibility mode |
| cpu_addr | input | 16 | CPU memory address |
| ram_addr | output | 19 | Physical RAM address |

## Verification
The bench targets writes that look like mapper writes but are not. These include writes with address bit 15 set and writes whose data bits 7:6 are 00, 01 or 10. A design with a loose decode would take over palette or mode writes and remap memory. In extended mode the bench writes each window separately and checks that the other windows stay unchanged. It sets data bit 5 to catch a design that lets bit 5 spill into the block number. In compatibility mode the bench runs all eight layouts with a non-zero group and also writes through address bits 9:8 = 00. A design that swaps the group and base blocks, or only honours one port address, would then show wrong blocks in specific windows. Last, the bench toggles the mode with no write, which catches a design that recomputes the map from the live mode input.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
  localparam int CPU_AW   = 16;
  localparam int IO_DW    = 8;
  localparam int BLK_W    = 5;
  localparam int PAGES    = 4;
  localparam int PSEL_W   = $clog2(PAGES);
  localparam int OFFS_W   = CPU_AW - PSEL_W;
  localparam int GRP_W    = BLK_W - PSEL_W;
  localparam int LAY_W    = 3;
  localparam int RAM_AW   = BLK_W + OFFS_W;

  typedef logic [BLK_W-1:0]            blk_t;
  typedef logic [PAGES-1:0][BLK_W-1:0] map_t;

  // Expand an expansion-style configuration code into a full window map.
  function automatic map_t compat_layout(input logic [LAY_W-1:0] lay,
                                         input logic [GRP_W-1:0] grp);
    map_t m;
    for (int i = 0; i < PAGES; i++) m[i] = BLK_W'(i);
    case (lay)
      3'd0: ;
      3'd1: m[3] = {grp, 2'd3};
      3'd2: for (int i = 0; i < PAGES; i++) m[i] = {grp, PSEL_W'(i)};
      3'd3: begin m[1] = BLK_W'(3); m[3] = {grp, 2'd3}; end
      default: m[1] = {grp, lay[1:0]};
    endcase
    return m;
  endfunction
endpackage

// File: rtl/mapper_io_decode.sv
module mapper_io_decode
  import mapper_pkg::*;
(
  input  logic                     io_wr,
  input  logic [CPU_AW-1:0]        io_addr,
  input  logic [IO_DW-1:0]         io_data,
  input  logic                     ext_mode,
  output logic                     wr_claim,
  output logic                     wr_bcast,
  output logic [PSEL_W-1:0]        wr_page,
  output logic [IO_DW-3:0]         wr_code
);
  // Claim needs A15 low and the two top data bits set.
  assign wr_claim = io_wr && !io_addr[CPU_AW-1] && (io_data[IO_DW-1 -: 2] == 2'b11);
  assign wr_bcast = !ext_mode;
  assign wr_page  = io_addr[8 +: PSEL_W];
  assign wr_code  = io_data[IO_DW-3:0];
endmodule

// File: rtl/mapper_page_regs.sv
module mapper_page_regs
  import mapper_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_claim,
  input  logic               wr_bcast,
  input  logic [PSEL_W-1:0]  wr_page,
  input  logic [IO_DW-3:0]   wr_code,
  output map_t               pmap
);
  map_t layout;
  assign layout = compat_layout(wr_code[LAY_W-1:0], wr_code[LAY_W +: GRP_W]);

  for (genvar p = 0; p < PAGES; p++) begin : g_page
    always_ff @(posedge clk) begin
      if (!rst_n)
        pmap[p] <= BLK_W'(p);
      else if (wr_claim && wr_bcast)
        pmap[p] <= layout[p];
      else if (wr_claim && (wr_page == PSEL_W'(p)))
        pmap[p] <= wr_code[BLK_W-1:0];
    end

    AST_OTHER_PAGE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_claim && !wr_bcast && wr_page != PSEL_W'(p)) |=> $stable(pmap[p])); // R4
  end

  AST_IDLE_KEEPS_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_claim |=> $stable(pmap)); // R1

  AST_COMPAT_WIN2_BASE_OR_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_claim && wr_bcast) |=>
      (pmap[2] == BLK_W'(2) || pmap[2] == {$past(wr_code[LAY_W +: GRP_W]), 2'd2})); // R6

  AST_COMPAT_CODE0_LINEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_claim && wr_bcast && wr_code == '0) |=>
      (pmap[0] == 5'd0 && pmap[1] == 5'd1 && pmap[2] == 5'd2 && pmap[3] == 5'd3)); // R6
endmodule

// File: rtl/mapper_addr_mux.sv
module mapper_addr_mux
  import mapper_pkg::*;
(
  input  map_t               pmap,
  input  logic [CPU_AW-1:0]  cpu_addr,
  output logic [RAM_AW-1:0]  ram_addr
);
  logic [PSEL_W-1:0] win;
  assign win      = cpu_addr[CPU_AW-1 -: PSEL_W];
  assign ram_addr = {pmap[win], cpu_addr[OFFS_W-1:0]};
endmodule

// File: rtl/paged_ram_mapper.sv
module paged_ram_mapper
  import mapper_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               io_wr,
  input  logic [15:0]        io_addr,
  input  logic [7:0]         io_data,
  input  logic               ext_mode,
  input  logic [15:0]        cpu_addr,
  output logic [18:0]        ram_addr
);
  logic              wr_claim, wr_bcast;
  logic [PSEL_W-1:0] wr_page;
  logic [IO_DW-3:0]  wr_code;
  map_t              pmap;

  mapper_io_decode u_dec (
    .io_wr(io_wr), .io_addr(io_addr), .io_data(io_data), .ext_mode(ext_mode),
    .wr_claim(wr_claim), .wr_bcast(wr_bcast), .wr_page(wr_page), .wr_code(wr_code)
  );

  mapper_page_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_claim(wr_claim), .wr_bcast(wr_bcast),
    .wr_page(wr_page), .wr_code(wr_code), .pmap(pmap)
  );

  mapper_addr_mux u_mux (.pmap(pmap), .cpu_addr(cpu_addr), .ram_addr(ram_addr));

  AST_FOREIGN_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && (io_addr[15] || io_data[7:6] != 2'b11)) |=> $stable(pmap)); // R1

  AST_EXT_LOADS_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && ext_mode && !io_addr[15] && io_data[7:6] == 2'b11)
      |=> pmap[$past(io_addr[9:8])] == $past(io_data[4:0])); // R4

  AST_MODE_ONLY_NO_REMAP: assert property (@(posedge clk) disable iff (!rst_n)
    !io_wr |=> $stable(pmap)); // R7
endmodule

// File: tb/paged_ram_mapper_test.sv
module paged_ram_mapper_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        io_wr = 0;
  logic [15:0] io_addr = 0;
  logic [7:0]  io_data = 0;
  logic        ext_mode = 1;
  logic [15:0] cpu_addr = 0;
  logic [18:0] ram_addr;
  int checks = 0;
  int fails = 0;
  logic [4:0] exp_map [4];

  always #4 clk = ~clk;

  paged_ram_mapper uut (.clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
    .io_data(io_data), .ext_mode(ext_mode), .cpu_addr(cpu_addr), .ram_addr(ram_addr));

  task automatic check_win(input int w, input logic [13:0] off, input string req);
    logic [18:0] exp;
    cpu_addr = {w[1:0], off};
    #1;
    exp = {exp_map[w], off};
    checks++;
    if (ram_addr !== exp) begin
      fails++;
      $display("FAIL %s window %0d: got %h expected %h", req, w, ram_addr, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int w = 0; w < 4; w++) check_win(w, 14'h1A5 + 14'(w * 77), req);
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_data = d; io_wr = 1;
    @(negedge clk);
    io_wr = 0;
  endtask

  function automatic void model_compat(input logic [5:0] code);
    logic [2:0] g = code[5:3];
    logic [2:0] l = code[2:0];
    for (int i = 0; i < 4; i++) exp_map[i] = 5'(i);
    case (l)
      3'd0: ;
      3'd1: exp_map[3] = {g, 2'd3};
      3'd2: for (int i = 0; i < 4; i++) exp_map[i] = {g, 2'(i)};
      3'd3: begin exp_map[1] = 5'd3; exp_map[3] = {g, 2'd3}; end
      default: exp_map[1] = {g, l[1:0]};
    endcase
  endfunction

  task automatic t_reset;
    rst_n = 0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 4; i++) exp_map[i] = 5'(i);
    check_all("R2");
    rst_n = 1;
    @(negedge clk);
    check_all("R2");
  endtask

  task automatic t_ext_pages;
    ext_mode = 1;
    for (int p = 0; p < 4; p++) begin
      logic [4:0] b = 5'(9 + p * 6);
      io_write({6'b011111, p[1:0], 8'h00}, {3'b110, b});
      exp_map[p] = b;
      check_all("R4");
    end
    check_win(2, 14'h0000, "R3");
    check_win(3, 14'h3FFF, "R3");
  endtask

  task automatic t_ext_bit5;
    ext_mode = 1;
    io_write(16'h7D00, 8'b1110_0110);
    exp_map[1] = 5'd6;
    check_all("R5");
  endtask

  task automatic t_foreign;
    io_write(16'hFF00, 8'hC3);
    check_all("R1");
    io_write(16'h7F00, 8'h43);
    check_all("R1");
    io_write(16'h7F00, 8'h83);
    check_all("R1");
    io_write(16'h7F00, 8'h03);
    check_all("R1");
    ext_mode = 0;
    io_write(16'hFC00, 8'hD2);
    check_all("R1");
    ext_mode = 1;
  endtask

  task automatic t_compat;
    ext_mode = 0;
    for (int l = 0; l < 8; l++) begin
      logic [5:0] code = {3'd5, 3'(l)};
      io_write(16'h7F00, {2'b11, code});
      model_compat(code);
      check_all("R6");
    end
    io_write(16'h7C00, {2'b11, 3'd6, 3'd2});
    model_compat({3'd6, 3'd2});
    check_all("R6");
  endtask

  task automatic t_mode_switch;
    @(negedge clk); ext_mode = 1;
    repeat (3) @(negedge clk);
    check_all("R7");
    ext_mode = 0;
    repeat (3) @(negedge clk);
    check_all("R7");
    ext_mode = 1;
    io_write(16'h7E00, 8'hDF);
    exp_map[2] = 5'd31;
    check_all("R4");
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_ext_pages();
        t_ext_bit5();
        t_foreign();
        t_compat();
        t_mode_switch();
      end
      begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule